// File: doc/BRIEF.md
# Flash Read Data Path with Write-Status Polling

This block forms the byte a parallel flash returns on each read cycle. When no internal write is in progress it passes the array byte through. When identification mode is active it returns the manufacturer or device code instead. While an internal program or erase is running it returns a status byte. In that byte, bit 7 carries a completion flag and bit 6 flips on every completed read, so software can poll for the end of the write either way.

The command decoder raises `busy_i` after the last write of a program or erase sequence. It also supplies the operation type and bit 7 of the byte being programmed. The array byte arrives on an input port. The pad driver uses `rd_oe_o` to control the data pins.

Top module: `flash_rd_path`

## Requirements
- R1: `rd_oe_o` is high exactly when `chip_en_i` and `out_en_i` are both high; while it is low, `rd_data_o` is 8'h00.
- R2: With `busy_i` low and `id_mode_i` low, `rd_data_o` equals `array_data_i`.
- R3: With `busy_i` low, `id_mode_i` high and `rd_addr_i` equal to 0, `rd_data_o` is the manufacturer code (parameter, default 8'hBF).
- R4: With `busy_i` low, `id_mode_i` high and `rd_addr_i` equal to 1, `rd_data_o` is the device code, 8'hB5 + (ADDR_W - 17): B5h for 17 address bits, B6h for 18 and B7h for 19.
- R5: In identification mode, when any address bit above bit 0 is set, `rd_data_o` equals `array_data_i`.
- R6: While `busy_i` is high and `op_erase_i` is low (program), bit 7 of `rd_data_o` is the inverse of `prog_d7_i`.
- R7: While `busy_i` is high and `op_erase_i` is high (erase), bit 7 of `rd_data_o` is 0.
- R8: While `busy_i` is high, bits 5 to 0 of `rd_data_o` equal bits 5 to 0 of `array_data_i`.
- R9: While `busy_i` is high, bit 6 reads 1 on the first read and flips after each completed read. A completed read is a clock edge with `rd_strobe_i` high and `rd_oe_o` high.
- R10: A strobe while `rd_oe_o` is low leaves the bit 6 phase unchanged.
- R11: `busy_i` takes priority over `id_mode_i`.
- R12: Once `busy_i` falls, true data returns at once. The next operation starts bit 6 at 1 again, whatever phase the last operation ended in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip selected, active high |
| out_en_i | input | 1 | Output enable requested, active high |
| rd_strobe_i | input | 1 | Read cycle completes at this clock edge |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| array_data_i | input | 8 | Byte read from the array |
| id_mode_i | input | 1 | Identification mode active |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation type: 1 erase, 0 program |
| prog_d7_i | input | 1 | Bit 7 of the byte being programmed |
| rd_data_o | output | 8 | Read data |
| rd_oe_o | output | 1 | Drive enable for the data pins |

## Verification
The bench builds two copies of the block, one with ADDR_W = 17 and one with ADDR_W = 19. Between them they reach the lowest and highest device codes, so the computed code is checked at both ends of its range. Small address and data widths let the bench sweep every array byte and every output-enable combination, and walk a set bit through every address position in identification mode. Long runs of reads under program and erase, with disabled strobes mixed in, check the toggle phase against a model kept in the bench.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;

  localparam int unsigned BASE_ADDR_W = 17;
  localparam logic [7:0]  BASE_DEV    = 8'hB5;

  // device code steps by one for each doubling of the array
  function automatic logic [7:0] dev_code(input int unsigned addr_w);
    int unsigned step;
    step = (addr_w > BASE_ADDR_W) ? (addr_w - BASE_ADDR_W) : 0;
    return BASE_DEV + step[7:0];
  endfunction

endpackage

// File: rtl/frp_toggle.sv
module frp_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_fire_i,
  output logic tgl_o
);

  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tgl_q <= 1'b1;
    else if (!busy_i)   tgl_q <= 1'b1;
    else if (rd_fire_i) tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;

  // R12
  idle_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> tgl_o);

  // R10
  hold_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_fire_i) |=> (tgl_o == $past(tgl_o)));

endmodule

// File: rtl/frp_ident.sv
module frp_ident
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter logic [7:0]  MFR_CODE = 8'hBF
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              hit_o,
  output logic [7:0]        code_o
);

  localparam logic [7:0] DEV_CODE = dev_code(ADDR_W);

  assign hit_o  = id_mode_i && (rd_addr_i[ADDR_W-1:1] == '0);
  assign code_o = rd_addr_i[0] ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/frp_status.sv
module frp_status (
  input  logic       op_erase_i,
  input  logic       prog_d7_i,
  input  logic       tgl_i,
  input  logic [5:0] array_lo_i,
  output logic [7:0] status_o
);

  logic done_n;

  always_comb begin
    done_n   = op_erase_i ? 1'b0 : ~prog_d7_i;
    status_o = {done_n, tgl_i, array_lo_i};
  end

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter logic [7:0]  MFR_CODE = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              out_en_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  input  logic              id_mode_i,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic              prog_d7_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_oe_o
);

  logic       rd_fire;
  logic       tgl;
  logic       id_hit;
  logic [7:0] id_code;
  logic [7:0] status_byte;
  rd_src_e    src;
  logic [7:0] sel_byte;

  assign rd_oe_o = chip_en_i & out_en_i;
  assign rd_fire = rd_strobe_i & rd_oe_o;

  frp_toggle u_toggle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .rd_fire_i (rd_fire),
    .tgl_o     (tgl)
  );

  frp_ident #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE)) u_ident (
    .id_mode_i (id_mode_i),
    .rd_addr_i (rd_addr_i),
    .hit_o     (id_hit),
    .code_o    (id_code)
  );

  frp_status u_status (
    .op_erase_i (op_erase_i),
    .prog_d7_i  (prog_d7_i),
    .tgl_i      (tgl),
    .array_lo_i (array_data_i[5:0]),
    .status_o   (status_byte)
  );

  // busy outranks identification, identification outranks array
  always_comb begin
    if (busy_i)      src = SRC_STATUS;
    else if (id_hit) src = SRC_IDENT;
    else             src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_STATUS: sel_byte = status_byte;
      SRC_IDENT:  sel_byte = id_code;
      default:    sel_byte = array_data_i;
    endcase
  end

  assign rd_data_o = rd_oe_o ? sel_byte : 8'h00;

  // R1
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> (rd_data_o == 8'h00));

  // R2
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && !busy_i && !id_mode_i) |-> (rd_data_o == array_data_i));

  // R6
  prog_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && busy_i && !op_erase_i) |-> (rd_data_o[7] == !prog_d7_i));

  // R7
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && busy_i && op_erase_i) |-> (rd_data_o[7] == 1'b0));

  // R8
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && busy_i) |-> (rd_data_o[5:0] == array_data_i[5:0]));

  // R9
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_fire) |=> (!(busy_i && rd_oe_o) || (rd_data_o[6] != $past(rd_data_o[6]))));

  // R12
  first_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i) |=> (!(busy_i && rd_oe_o) || rd_data_o[6]));

endmodule

// File: tb/flash_rd_path_bench.sv
`timescale 1ns/1ps
module flash_rd_path_bench;

  localparam int unsigned AW  = 17;
  localparam int unsigned AW2 = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, oe = 1'b0, strobe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW2-1:0] addr2 = '0;
  logic [7:0]    arr = 8'h00;
  logic          idm = 1'b0, busy = 1'b0, erase = 1'b0, pd7 = 1'b0;
  logic [7:0]    dout, dout2;
  logic          doe, doe2;

  int n_vec = 0;
  int n_bad = 0;
  logic exp_tgl;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_rd_path #(.ADDR_W(AW)) u_flash_rd_path (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .out_en_i(oe),
    .rd_strobe_i(strobe), .rd_addr_i(addr), .array_data_i(arr),
    .id_mode_i(idm), .busy_i(busy), .op_erase_i(erase), .prog_d7_i(pd7),
    .rd_data_o(dout), .rd_oe_o(doe));

  flash_rd_path #(.ADDR_W(AW2)) u_flash_rd_path_w19 (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .out_en_i(oe),
    .rd_strobe_i(1'b0), .rd_addr_i(addr2), .array_data_i(arr),
    .id_mode_i(idm), .busy_i(1'b0), .op_erase_i(1'b0), .prog_d7_i(1'b0),
    .rd_data_o(dout2), .rd_oe_o(doe2));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // one completed read under busy; status checked before the edge
  task automatic busy_read(input string req, input bit enabled);
    @(negedge clk);
    arr = arr + 8'h25;
    ce = 1'b1; oe = enabled; strobe = 1'b1;
    #1;
    if (enabled) begin
      chk(req, dout, {erase ? 1'b0 : ~pd7, exp_tgl, arr[5:0]});
      exp_tgl = ~exp_tgl;
    end else chk("R10 disabled strobe", dout, 8'h00);
    @(negedge clk);
    strobe = 1'b0; oe = 1'b1;
    #1;
    chk("R9 phase peek", {7'd0, dout[6]}, {7'd0, exp_tgl});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", {7'd0, doe}, 8'd0);
    chk("R1 reset data", dout, 8'h00);
    rst_n = 1'b1;

    // R1: all enable combinations over all array bytes
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 256; d++) begin
        @(negedge clk);
        ce = e[0]; oe = e[1]; arr = d[7:0];
        #1;
        chk("R1 oe", {7'd0, doe}, {7'd0, e[0] & e[1]});
        chk("R2 idle data", dout, (e == 3) ? d[7:0] : 8'h00);
      end
    end

    // R3/R4/R5 identification
    ce = 1'b1; oe = 1'b1; idm = 1'b1; arr = 8'h3C;
    @(negedge clk);
    addr = 0; addr2 = 0; #1;
    chk("R3 mfr", dout, 8'hBF);
    chk("R3 mfr w19", dout2, 8'hBF);
    addr = 1; addr2 = 1; #1;
    chk("R4 dev w17", dout, 8'hB5);
    chk("R4 dev w19", dout2, 8'hB7);
    for (int b = 1; b < AW; b++) begin
      addr = '0; addr[b] = 1'b1; addr[0] = b[0]; #1;
      chk("R5 high addr", dout, 8'h3C);
    end
    for (int b = 1; b < AW2; b++) begin
      addr2 = '0; addr2[b] = 1'b1; #1;
      chk("R5 high addr w19", dout2, 8'h3C);
    end

    // R6/R8/R9/R11: program, with id mode still set
    addr = 1;
    for (int op = 0; op < 4; op++) begin
      @(negedge clk);
      busy = 1'b1; erase = op[0]; pd7 = op[1];
      exp_tgl = 1'b1;
      #1;
      chk(op[0] ? "R7 erase first" : "R11 busy over id", dout,
          {op[0] ? 1'b0 : ~op[1], 1'b1, arr[5:0]});
      for (int k = 0; k < 9; k++)
        busy_read(op[0] ? "R7 erase poll" : "R6 program poll", (k % 4) != 3);
      // R12: leave busy on a 0 phase when possible, then finish
      @(negedge clk);
      busy = 1'b0; idm = 1'b0; arr = 8'hA6; #1;
      chk("R12 true data", dout, 8'hA6);
      idm = 1'b1;
    end

    // R8 sweep of low bits during busy
    @(negedge clk);
    busy = 1'b1; erase = 1'b0; pd7 = 1'b1;
    for (int d = 0; d < 256; d++) begin
      arr = d[7:0]; #1;
      chk("R8 low bits", dout & 8'h3F, d[7:0] & 8'h3F);
      chk("R6 bit7", dout & 8'h80, 8'h00);
    end
    @(negedge clk);
    busy = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule